// File: doc/BRIEF.md
# Instruction-Count Fetch Thread Selector

This block chooses, every cycle, which hardware thread of a simultaneous-multithreading front end gets the fetch slot. It keeps a live count of instructions in flight for each thread. The count rises by the number of instructions fetched for that thread and falls by the numbers retired and flushed. The thread with the lowest count wins. This steers fetch bandwidth toward threads that are draining the shared machine quickly and away from threads that are clogging it.

Two conditions remove a thread from the choice. A thread whose count has reached a per-thread cap is held off, so that no single thread can fill the shared instruction queue. A thread may also sleep. A load first arms a watch address for the thread, and a later quiesce operation puts that thread to sleep. The thread then stays out of scheduling until a snooped store hits its watched address, which wakes it and disarms the watch. Ties on count are resolved by a per-thread priority weight that software can configure, and after that by the lower thread number.

The selection is combinational from registered state. Inputs sampled at a clock edge affect the output after that edge.

Top module: `fetch_thread_selector`

## Requirements
- R1: Each thread's in-flight count becomes count + fetched − retired − flushed at every clock edge. It saturates at zero below and at QUEUE_DEPTH (32) above.
- R2: When `fetchValid` is 1, `fetchThread` names an eligible thread with the smallest in-flight count. A thread is eligible when it is not asleep and its count is below the cap.
- R3: Among eligible threads with equal smallest count, the one with the numerically larger priority weight (field `t*2 +: 2` of `prioWeights`) is chosen.
- R4: When both count and priority weight are tied, the lowest thread number is chosen.
- R5: A thread whose count is at or above THREAD_CAP (default QUEUE_DEPTH/2 = 16) is never selected.
- R6: A quiesce request for thread `quiesceTid` puts it to sleep at the next edge only if that thread has an armed watch. Without an armed watch the request is ignored.
- R7: A snoop with `snoopAddr` equal to the watched address of a sleeping thread wakes that thread and disarms its watch. A later quiesce of that thread is then ignored until it is armed again. A watch set in the same cycle takes precedence over the disarm.
- R8: A snoop whose address matches no sleeping thread's watched address changes nothing.
- R9: When no thread is eligible, `fetchValid` is 0 and `fetchThread` is 0.
- R10: After reset, all counts are zero, no thread sleeps and no watch is armed, so thread 0 is selected with `fetchValid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchCnt | input | 4*3 | Per-thread count of instructions fetched this cycle (field t*3) |
| retireCnt | input | 4*3 | Per-thread count of instructions retired this cycle |
| flushCnt | input | 4*3 | Per-thread count of instructions flushed this cycle |
| prioWeights | input | 4*2 | Per-thread tie-break priority, larger wins |
| watchSet | input | 1 | Arm a watch for `watchTid` at `watchAddr` |
| watchTid | input | 2 | Thread whose watch is armed |
| watchAddr | input | 16 | Address to watch |
| quiesceReq | input | 1 | Quiesce request |
| quiesceTid | input | 2 | Thread that quiesces |
| snoopValid | input | 1 | A store was observed |
| snoopAddr | input | 16 | Address of the observed store |
| fetchValid | output | 1 | Some thread may fetch |
| fetchThread | output | 2 | Thread granted the fetch slot |

## Verification
If a counter drifts, a sleep flag sticks, or a watch is lost, the chosen thread differs from a behavioural model. That difference shows on `fetchThread` or `fetchValid` in the first cycle where the faulty thread's rank matters. The bench therefore compares both outputs against the model after every clock. Counter saturation and wake-up faults can stay hidden until the counts of competing threads come close, so the directed sequences place counts in ties and at the cap. A long randomised run then mixes fetch, retire, flush and sleep traffic.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int THREADS = 4;

  typedef struct packed {
    logic [THREADS-1:0] disarm;
  } ctrlStrobe_t;
endpackage

// File: rtl/fts_datapath.sv
module fts_datapath #(
  parameter int QUEUE_DEPTH = 32,
  parameter int DW = 3,
  parameter int CW = 6,
  parameter int ADDR_W = 16,
  parameter int TID_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [fts_pkg::THREADS*DW-1:0] fetchCnt,
  input  logic [fts_pkg::THREADS*DW-1:0] retireCnt,
  input  logic [fts_pkg::THREADS*DW-1:0] flushCnt,
  input  logic watchSet,
  input  logic [TID_W-1:0] watchTid,
  input  logic [ADDR_W-1:0] watchAddr,
  input  logic snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  fts_pkg::ctrlStrobe_t strobes,
  output logic [fts_pkg::THREADS-1:0][CW-1:0] counts,
  output logic [fts_pkg::THREADS-1:0] armedVec,
  output logic [fts_pkg::THREADS-1:0] matchVec
);
  localparam int NT = fts_pkg::THREADS;
  localparam int WW = CW + 2;
  localparam logic [WW-1:0] DEPTH_V = WW'(QUEUE_DEPTH);

  logic [NT-1:0][ADDR_W-1:0] watchQ;

  for (genvar t = 0; t < NT; t++) begin : g_thread
    logic [WW-1:0] upVal;
    logic [WW-1:0] downVal;
    logic [WW-1:0] diffVal;
    logic [CW-1:0] cntNext;
    logic armHere;

    always_comb begin
      upVal   = WW'(counts[t]) + WW'(fetchCnt[t*DW +: DW]);
      downVal = WW'(retireCnt[t*DW +: DW]) + WW'(flushCnt[t*DW +: DW]);
      diffVal = (upVal > downVal) ? (upVal - downVal) : '0;
      cntNext = (diffVal > DEPTH_V) ? CW'(QUEUE_DEPTH) : CW'(diffVal);
    end

    assign armHere = watchSet && (watchTid == TID_W'(t));
    assign matchVec[t] = snoopValid && armedVec[t] && (watchQ[t] == snoopAddr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        counts[t]   <= '0;
        armedVec[t] <= 1'b0;
        watchQ[t]   <= '0;
      end else begin
        counts[t] <= cntNext;
        if (armHere) begin
          armedVec[t] <= 1'b1;
          watchQ[t]   <= watchAddr;
        end else if (strobes.disarm[t]) begin
          armedVec[t] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fts_control.sv
module fts_control #(
  parameter int CW = 6,
  parameter int PW = 2,
  parameter int TID_W = 2,
  parameter int THREAD_CAP = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic [fts_pkg::THREADS-1:0][CW-1:0] counts,
  input  logic [fts_pkg::THREADS-1:0] armedVec,
  input  logic [fts_pkg::THREADS-1:0] matchVec,
  input  logic [fts_pkg::THREADS*PW-1:0] prioWeights,
  input  logic quiesceReq,
  input  logic [TID_W-1:0] quiesceTid,
  output fts_pkg::ctrlStrobe_t strobes,
  output logic [fts_pkg::THREADS-1:0] sleepVec,
  output logic fetchValid,
  output logic [TID_W-1:0] fetchThread
);
  localparam int NT = fts_pkg::THREADS;
  localparam logic [CW-1:0] CAP_V = CW'(THREAD_CAP);

  logic [NT-1:0] wakeVec;
  logic [NT-1:0] eligVec;

  assign wakeVec = matchVec & sleepVec;
  assign strobes.disarm = wakeVec;

  for (genvar t = 0; t < NT; t++) begin : g_sleep
    assign eligVec[t] = !sleepVec[t] && (counts[t] < CAP_V);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sleepVec[t] <= 1'b0;
      end else if (wakeVec[t]) begin
        sleepVec[t] <= 1'b0;
      end else if (quiesceReq && quiesceTid == TID_W'(t) && armedVec[t]) begin
        sleepVec[t] <= 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    logic [CW-1:0] bestCnt;
    logic [PW-1:0] bestPrio;
    found = 1'b0;
    bestCnt = '0;
    bestPrio = '0;
    fetchThread = '0;
    for (int t = 0; t < NT; t++) begin
      if (eligVec[t] && (!found || counts[t] < bestCnt ||
          (counts[t] == bestCnt && prioWeights[t*PW +: PW] > bestPrio))) begin
        found = 1'b1;
        bestCnt = counts[t];
        bestPrio = prioWeights[t*PW +: PW];
        fetchThread = TID_W'(t);
      end
    end
    fetchValid = found;
  end
endmodule

// File: rtl/fetch_thread_selector.sv
module fetch_thread_selector #(
  parameter int QUEUE_DEPTH = 32,
  parameter int FETCH_MAX = 4,
  parameter int ADDR_W = 16,
  parameter int PRIO_W = 2,
  parameter int THREAD_CAP = QUEUE_DEPTH / 2,
  localparam int NT = fts_pkg::THREADS,
  localparam int TID_W = $clog2(NT),
  localparam int DW = $clog2(FETCH_MAX + 1),
  localparam int CW = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NT*DW-1:0] fetchCnt,
  input  logic [NT*DW-1:0] retireCnt,
  input  logic [NT*DW-1:0] flushCnt,
  input  logic [NT*PRIO_W-1:0] prioWeights,
  input  logic watchSet,
  input  logic [TID_W-1:0] watchTid,
  input  logic [ADDR_W-1:0] watchAddr,
  input  logic quiesceReq,
  input  logic [TID_W-1:0] quiesceTid,
  input  logic snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic fetchValid,
  output logic [TID_W-1:0] fetchThread
);
  fts_pkg::ctrlStrobe_t strobes;
  logic [NT-1:0][CW-1:0] counts;
  logic [NT-1:0] armedVec;
  logic [NT-1:0] matchVec;
  logic [NT-1:0] sleepVec;

  fts_datapath #(
    .QUEUE_DEPTH(QUEUE_DEPTH), .DW(DW), .CW(CW), .ADDR_W(ADDR_W), .TID_W(TID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fetchCnt(fetchCnt), .retireCnt(retireCnt),
    .flushCnt(flushCnt), .watchSet(watchSet), .watchTid(watchTid),
    .watchAddr(watchAddr), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .strobes(strobes), .counts(counts), .armedVec(armedVec), .matchVec(matchVec)
  );

  fts_control #(
    .CW(CW), .PW(PRIO_W), .TID_W(TID_W), .THREAD_CAP(THREAD_CAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .counts(counts), .armedVec(armedVec),
    .matchVec(matchVec), .prioWeights(prioWeights), .quiesceReq(quiesceReq),
    .quiesceTid(quiesceTid), .strobes(strobes), .sleepVec(sleepVec),
    .fetchValid(fetchValid), .fetchThread(fetchThread)
  );
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int NT = 4,
  parameter int CW = 6,
  parameter int TID_W = 2,
  parameter int THREAD_CAP = 16
) (
  input logic clk,
  input logic rstN,
  input logic fetchValid,
  input logic [TID_W-1:0] fetchThread,
  input logic [NT-1:0][CW-1:0] counts,
  input logic [NT-1:0] sleepVec,
  input logic [NT-1:0] armedVec
);
  localparam logic [CW-1:0] CAP_V = CW'(THREAD_CAP);

  logic [NT-1:0] okVec;
  logic [NT-1:0] minOk;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      okVec[t] = !sleepVec[t] && (counts[t] < CAP_V);
      minOk[t] = !okVec[t] || (counts[t] >= counts[fetchThread]);
    end
  end

  assert_pick_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> okVec[fetchThread]);

  assert_pick_awake_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !sleepVec[fetchThread]);

  assert_pick_min_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (&minOk));

  assert_idle_none_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (okVec == '0 && fetchThread == '0));

  assert_sleep_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sleepVec & ~armedVec) == '0);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (sleepVec == '0 && armedVec == '0));
endmodule

bind fetch_thread_selector fts_checker #(
  .NT(NT), .CW(CW), .TID_W(TID_W), .THREAD_CAP(THREAD_CAP)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchThread(fetchThread),
  .counts(counts), .sleepVec(sleepVec), .armedVec(armedVec)
);

// File: tb/test_fetch_thread_selector.sv
`timescale 1ns/1ps
module test_fetch_thread_selector;
  localparam int NT = 4;
  localparam int DW = 3;
  localparam int PW = 2;
  localparam int AW = 16;
  localparam int DEPTH = 32;
  localparam int CAP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NT*DW-1:0] fetchCnt, retireCnt, flushCnt;
  logic [NT*PW-1:0] prioWeights;
  logic watchSet = 1'b0, quiesceReq = 1'b0, snoopValid = 1'b0;
  logic [1:0] watchTid = '0, quiesceTid = '0;
  logic [AW-1:0] watchAddr = '0, snoopAddr = '0;
  logic fetchValid;
  logic [1:0] fetchThread;

  int fArr[NT], rArr[NT], flArr[NT], pArr[NT];
  int mCnt[NT], mWatch[NT];
  bit mSleep[NT], mArmed[NT];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      fetchCnt[t*DW +: DW]  = DW'(fArr[t]);
      retireCnt[t*DW +: DW] = DW'(rArr[t]);
      flushCnt[t*DW +: DW]  = DW'(flArr[t]);
      prioWeights[t*PW +: PW] = PW'(pArr[t]);
    end
  end

  fetch_thread_selector i_fetch_thread_selector (
    .clk(clk), .rstN(rstN), .fetchCnt(fetchCnt), .retireCnt(retireCnt),
    .flushCnt(flushCnt), .prioWeights(prioWeights), .watchSet(watchSet),
    .watchTid(watchTid), .watchAddr(watchAddr), .quiesceReq(quiesceReq),
    .quiesceTid(quiesceTid), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .fetchValid(fetchValid), .fetchThread(fetchThread)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  // Reference choice: lowest count, then larger weight, then lower id.
  function automatic int expPick();
    int best = -1;
    for (int t = 0; t < NT; t++) begin
      if (!mSleep[t] && mCnt[t] < CAP) begin
        if (best < 0 || mCnt[t] < mCnt[best] ||
            (mCnt[t] == mCnt[best] && pArr[t] > pArr[best])) best = t;
      end
    end
    return best;
  endfunction

  task automatic modelEdge();
    bit wake[NT];
    for (int t = 0; t < NT; t++)
      wake[t] = snoopValid && mSleep[t] && mArmed[t] && mWatch[t] == int'(snoopAddr);
    for (int t = 0; t < NT; t++) begin
      int n = mCnt[t] + fArr[t] - rArr[t] - flArr[t];
      bit armedNow = mArmed[t];
      mCnt[t] = (n < 0) ? 0 : (n > DEPTH ? DEPTH : n);
      if (watchSet && int'(watchTid) == t) begin
        mArmed[t] = 1; mWatch[t] = int'(watchAddr);
      end else if (wake[t]) mArmed[t] = 0;
      if (wake[t]) mSleep[t] = 0;
      else if (quiesceReq && int'(quiesceTid) == t && armedNow) mSleep[t] = 1;
    end
  endtask

  task automatic compare(string tag);
    int e = expPick();
    bit ev = (e >= 0);
    int et = ev ? e : 0;
    checks++;
    if (fetchValid !== ev || int'(fetchThread) != et) begin
      fails++;
      $display("FAIL %s: actual valid=%0d thread=%0d expected valid=%0d thread=%0d",
               tag, fetchValid, fetchThread, ev, et);
    end
  endtask

  task automatic clearIn();
    for (int t = 0; t < NT; t++) begin fArr[t] = 0; rArr[t] = 0; flArr[t] = 0; end
    watchSet = 0; quiesceReq = 0; snoopValid = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(tag);
    clearIn();
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin
      pArr[t] = 0; mCnt[t] = 0; mWatch[t] = 0; mSleep[t] = 0; mArmed[t] = 0;
    end
    clearIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R10");

    fArr[0] = 3; step("R2");
    fArr[1] = 2; fArr[2] = 1; fArr[3] = 4; step("R2");
    pArr[3] = 3; rArr[3] = 3; step("R3");
    pArr[3] = 0; step("R4");
    rArr[0] = 4; flArr[0] = 3; step("R1");
    for (int i = 0; i < 4; i++) begin fArr[0] = 4; step("R5"); end

    watchSet = 1; watchTid = 2; watchAddr = 16'h0040; step("R6");
    quiesceReq = 1; quiesceTid = 2; step("R6");
    quiesceReq = 1; quiesceTid = 1; fArr[3] = 4; step("R6");
    snoopValid = 1; snoopAddr = 16'h0041; fArr[1] = 4; step("R8");
    snoopValid = 1; snoopAddr = 16'h0040; step("R7");
    quiesceReq = 1; quiesceTid = 2; step("R7");

    for (int t = 1; t < NT; t++) begin
      watchSet = 1; watchTid = 2'(t); watchAddr = 16'(16'h0100 + t); step("R9");
    end
    for (int t = 1; t < NT; t++) begin
      quiesceReq = 1; quiesceTid = 2'(t); step("R9");
    end
    snoopValid = 1; snoopAddr = 16'h0103; step("R9");
    for (int i = 0; i < 6; i++) begin rArr[0] = 4; flArr[0] = 3; step("R1"); end

    for (int i = 0; i < 3000; i++) begin
      if (fetchValid) fArr[fetchThread] = int'($urandom_range(0, 4));
      for (int t = 0; t < NT; t++) begin
        rArr[t] = int'($urandom_range(0, 2));
        flArr[t] = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 4)) : 0;
      end
      if ($urandom_range(0, 31) == 0) pArr[$urandom_range(0, NT-1)] = int'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) begin
        watchSet = 1; watchTid = 2'($urandom_range(0, NT-1)); watchAddr = 16'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 5) == 0) begin
        quiesceReq = 1; quiesceTid = 2'($urandom_range(0, NT-1));
      end
      if ($urandom_range(0, 3) == 0) begin
        snoopValid = 1; snoopAddr = 16'($urandom_range(0, 3));
      end
      step("R2");
    end
    summary();
  end
endmodule